// File: doc/BRIEF.md
# Register Redirection Table

This block holds the register redirection entries that turn ordinary scalar register numbers into redirected, possibly vectorised, register references. Up to four entries arrive one at a time over a valid/ready load stream. Each entry is either a full 16-bit entry or a compact 8-bit entry. The compact form is widened to the full form on the way in. The block then files each entry into one of two 32-slot direct lookup tables, one for integer registers and one for floating-point registers. The slot it writes is the entry's key register number. A lookup therefore costs one table read instead of a key compare across all entries.

The lookup side is a plain combinational query. It takes a register number and a class flag. It returns the real register index, the vector flag, the element-width override and a hit flag. A plain clear pin empties both tables in one cycle and reopens the load stream.

Load stream back-pressure rules: an entry moves on a clock edge where `ent_valid` and `ent_ready` are both high. `ent_ready` is low while `tbl_clear` is high. It is also low once four entries have moved since the last clear or reset. A producer that sees `ent_ready` low keeps its entry and `ent_valid` until ready returns. While ready is low, entries are not taken.

Top module: `regredir_table`

## Requirements
- R1: A full entry (`ent_compact`=0) has key in bits 4:0, width override in bits 6:5, class in bit 7, 7-bit real register index in bits 14:8 and vector flag in bit 15. After it is loaded, a lookup of that key and class returns those three values with `q_hit`=1.
- R2: A compact entry (`ent_compact`=1) uses bits 7:0 only: key in 4:0, width in 6:5, class in 7. It loads with vector flag 1 and real index equal to key*4, which is {key,2'b00}.
- R3: Class bit value 1 selects the integer table and 0 selects the floating-point table. An entry in one class never answers a lookup made with the other class (`q_is_int`).
- R4: A lookup whose slot is not enabled returns `q_ridx` equal to the zero-extended `q_reg`, `q_vector`=0, `q_width`=2'b00 (default width) and `q_hit`=0.
- R5: `tbl_clear` high at a clock edge disables all 64 slots, so lookups miss from the next cycle on. `ent_ready` is low while `tbl_clear` is high, so an entry offered in that cycle is not loaded.
- R6: When two loaded entries share a key and class, the one loaded later sets the slot's contents.
- R7: After four entries have been accepted since the last clear or reset, `ent_ready` stays low and further offered entries change nothing until the next clear.
- R8: After reset, every lookup misses and `ent_ready` is high.
- R9: A load is visible on the lookup port in the cycle after its handshake edge. A cycle with `ent_valid` low changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_clear | input | 1 | Disable every slot and restart the entry count |
| ent_valid | input | 1 | Load stream: entry offered |
| ent_ready | output | 1 | Load stream: entry can be taken |
| ent_data | input | 16 | Entry bits (only 7:0 used in compact form) |
| ent_compact | input | 1 | 1 = compact 8-bit entry, 0 = full 16-bit entry |
| q_reg | input | 5 | Register number to look up |
| q_is_int | input | 1 | 1 = integer class, 0 = floating-point class |
| q_ridx | output | 7 | Real register index |
| q_vector | output | 1 | 1 = register advances per element, 0 = scalar |
| q_width | output | 2 | Width override: 00 default, 01 8-bit, 10 16-bit, 11 32-bit |
| q_hit | output | 1 | An enabled slot answered the lookup |

## Verification
The hardest case to reach is the stream with the entry limit used up, while an entry is still offered. The bench gets there by loading four entries of mixed class and form, which brings ready down. It then holds a fifth entry valid against a slot that is already filled and checks that the slot keeps its old contents. Clear with a simultaneous offer is reached by raising both in the same cycle. Each lookup is then run in the cycle after the edge that should have changed it.

// File: rtl/regredir_pkg.sv
package regredir_pkg;
  localparam int REG_AW  = 5;
  localparam int NREG    = 1 << REG_AW;
  localparam int RIDX_W  = 7;
  localparam int WID_W   = 2;
  localparam int ENT_W   = 16;
  localparam int CPT_SHIFT = RIDX_W - REG_AW;

  typedef struct packed {
    logic              vec;
    logic [RIDX_W-1:0] ridx;
    logic [WID_W-1:0]  wid;
  } slot_t;

  typedef struct packed {
    logic [REG_AW-1:0] key;
    logic              is_int;
    slot_t             body;
  } entry_t;

  function automatic entry_t unpack_full(input logic [ENT_W-1:0] raw);
    entry_t e;
    e.key       = raw[4:0];
    e.body.wid  = raw[6:5];
    e.is_int    = raw[7];
    e.body.ridx = raw[14:8];
    e.body.vec  = raw[15];
    return e;
  endfunction

  function automatic entry_t unpack_compact(input logic [7:0] raw);
    entry_t e;
    e.key       = raw[4:0];
    e.body.wid  = raw[6:5];
    e.is_int    = raw[7];
    e.body.ridx = {raw[4:0], {CPT_SHIFT{1'b0}}};
    e.body.vec  = 1'b1;
    return e;
  endfunction
endpackage

// File: rtl/regredir_expand.sv
module regredir_expand
  import regredir_pkg::*;
(
  input  logic [ENT_W-1:0] raw,
  input  logic             compact,
  output entry_t           ent
);
  entry_t full_e;
  entry_t cpt_e;

  always_comb begin
    full_e = unpack_full(raw);
    cpt_e  = unpack_compact(raw[7:0]);
    ent    = compact ? cpt_e : full_e;
  end
endmodule

// File: rtl/regredir_bank.sv
module regredir_bank
  import regredir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_key,
  input  slot_t             wr_body,
  input  logic [REG_AW-1:0] rd_key,
  output slot_t             rd_body,
  output logic              rd_en
);
  slot_t            body_q [NREG];
  logic [NREG-1:0]  en_q;

  for (genvar s = 0; s < NREG; s++) begin : g_slot
    logic hit_w;
    assign hit_w = wr_en && (wr_key == REG_AW'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[s]   <= 1'b0;
        body_q[s] <= '0;
      end else if (clr) begin
        en_q[s]   <= 1'b0;
      end else if (hit_w) begin
        en_q[s]   <= 1'b1;
        body_q[s] <= wr_body;
      end
    end
  end

  always_comb begin
    rd_en   = en_q[rd_key];
    rd_body = body_q[rd_key];
  end
endmodule

// File: rtl/regredir_lookup.sv
module regredir_lookup
  import regredir_pkg::*;
(
  input  logic [REG_AW-1:0] q_reg,
  input  logic              q_is_int,
  input  slot_t             fp_body,
  input  logic              fp_en,
  input  slot_t             int_body,
  input  logic              int_en,
  output logic [RIDX_W-1:0] q_ridx,
  output logic              q_vector,
  output logic [WID_W-1:0]  q_width,
  output logic              q_hit
);
  slot_t sel_body;
  logic  sel_en;

  always_comb begin
    sel_body = q_is_int ? int_body : fp_body;
    sel_en   = q_is_int ? int_en   : fp_en;
    q_hit    = sel_en;
    if (sel_en) begin
      q_ridx   = sel_body.ridx;
      q_vector = sel_body.vec;
      q_width  = sel_body.wid;
    end else begin
      q_ridx   = {{CPT_SHIFT{1'b0}}, q_reg};
      q_vector = 1'b0;
      q_width  = '0;
    end
  end
endmodule

// File: rtl/regredir_table.sv
module regredir_table
  import regredir_pkg::*;
#(
  parameter int MAX_ENTRIES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tbl_clear,
  input  logic        ent_valid,
  output logic        ent_ready,
  input  logic [15:0] ent_data,
  input  logic        ent_compact,
  input  logic [4:0]  q_reg,
  input  logic        q_is_int,
  output logic [6:0]  q_ridx,
  output logic        q_vector,
  output logic [1:0]  q_width,
  output logic        q_hit
);
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1);
  localparam int NCLS  = 2;

  logic [CNT_W-1:0] taken_q;
  logic             xfer;
  entry_t           ent;

  slot_t            cls_body [NCLS];
  logic [NCLS-1:0]  cls_en;

  assign ent_ready = !tbl_clear && (taken_q < CNT_W'(MAX_ENTRIES));
  assign xfer      = ent_valid && ent_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         taken_q <= '0;
    else if (tbl_clear) taken_q <= '0;
    else if (xfer)      taken_q <= taken_q + 1'b1;
  end

  regredir_expand u_expand (
    .raw     (ent_data),
    .compact (ent_compact),
    .ent     (ent)
  );

  // class 0 = floating point, class 1 = integer
  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    regredir_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tbl_clear),
      .wr_en   (xfer && (ent.is_int == c[0])),
      .wr_key  (ent.key),
      .wr_body (ent.body),
      .rd_key  (q_reg),
      .rd_body (cls_body[c]),
      .rd_en   (cls_en[c])
    );
  end

  regredir_lookup u_lookup (
    .q_reg    (q_reg),
    .q_is_int (q_is_int),
    .fp_body  (cls_body[0]),
    .fp_en    (cls_en[0]),
    .int_body (cls_body[1]),
    .int_en   (cls_en[1]),
    .q_ridx   (q_ridx),
    .q_vector (q_vector),
    .q_width  (q_width),
    .q_hit    (q_hit)
  );
endmodule

// File: rtl/regredir_table_chk.sv
module regredir_table_chk #(
  parameter int MAX_ENTRIES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tbl_clear,
  input logic       ent_valid,
  input logic       ent_ready,
  input logic [4:0] q_reg,
  input logic       q_is_int,
  input logic [6:0] q_ridx,
  input logic       q_vector,
  input logic [1:0] q_width,
  input logic       q_hit
);
  localparam int CW = $clog2(MAX_ENTRIES + 1) + 1;
  logic [CW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        seen <= '0;
    else if (tbl_clear)                seen <= '0;
    else if (ent_valid && ent_ready)   seen <= seen + 1'b1;
  end

  // R4
  miss_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q_hit |-> (q_ridx == {2'b00, q_reg}) && !q_vector && (q_width == 2'b00));

  // R5
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_clear |=> !q_hit);

  // R5
  clear_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_clear |-> !ent_ready);

  // R7
  entry_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= CW'(MAX_ENTRIES)) |-> !ent_ready);

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ent_valid && ent_ready) && !tbl_clear) ##1 ($stable(q_reg) && $stable(q_is_int))
      |-> $stable(q_hit) && $stable(q_ridx));
endmodule

bind regredir_table regredir_table_chk #(.MAX_ENTRIES(MAX_ENTRIES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tbl_clear (tbl_clear),
  .ent_valid (ent_valid),
  .ent_ready (ent_ready),
  .q_reg     (q_reg),
  .q_is_int  (q_is_int),
  .q_ridx    (q_ridx),
  .q_vector  (q_vector),
  .q_width   (q_width),
  .q_hit     (q_hit)
);

// File: tb/tb_regredir_table.sv
`timescale 1ns/1ps
module tb_regredir_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_clear = 1'b0;
  logic        ent_valid = 1'b0;
  logic        ent_ready;
  logic [15:0] ent_data = '0;
  logic        ent_compact = 1'b0;
  logic [4:0]  q_reg = '0;
  logic        q_is_int = 1'b0;
  logic [6:0]  q_ridx;
  logic        q_vector;
  logic [1:0]  q_width;
  logic        q_hit;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  regredir_table dut (.*);

  function automatic logic [15:0] full_ent(input bit vec, input int ridx,
                                           input bit is_int, input int wid, input int key);
    return {vec, 7'(ridx), is_int, 2'(wid), 5'(key)};
  endfunction

  task automatic load(input logic [15:0] d, input bit cpt);
    @(negedge clk);
    ent_data = d; ent_compact = cpt; ent_valid = 1'b1;
    @(negedge clk);
    ent_valid = 1'b0;
  endtask

  task automatic expect_q(input string req, input int r, input bit is_int,
                          input bit hit, input int ridx, input bit vec, input int wid);
    q_reg = 5'(r); q_is_int = is_int;
    #1;
    total++;
    if (q_hit !== hit || q_ridx !== 7'(ridx) || q_vector !== vec || q_width !== 2'(wid)) begin
      bad++;
      $display("FAIL %s reg=%0d int=%0d got hit=%0d ridx=%0d vec=%0d wid=%0d exp hit=%0d ridx=%0d vec=%0d wid=%0d",
               req, r, is_int, q_hit, q_ridx, q_vector, q_width, hit, ridx, vec, wid);
    end
  endtask

  task automatic expect_ready(input string req, input bit exp);
    #1;
    total++;
    if (ent_ready !== exp) begin
      bad++;
      $display("FAIL %s ent_ready got %0d exp %0d", req, ent_ready, exp);
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    tbl_clear = 1'b1;
    expect_ready("R5", 1'b0);
    @(negedge clk);
    tbl_clear = 1'b0;
  endtask

  task automatic t_reset();
    expect_ready("R8", 1'b1);
    expect_q("R8", 5, 1, 0, 5, 0, 0);
    expect_q("R8", 31, 0, 0, 31, 0, 0);
  endtask

  task automatic t_full_and_class();
    load(full_ent(1, 'h55, 1, 2, 3), 0);
    expect_q("R1", 3, 1, 1, 'h55, 1, 2);
    expect_q("R3", 3, 0, 0, 3, 0, 0);
    load(full_ent(0, 'h12, 0, 1, 3), 0);
    expect_q("R1", 3, 0, 1, 'h12, 0, 1);
    expect_q("R3", 3, 1, 1, 'h55, 1, 2);
    expect_q("R4", 4, 1, 0, 4, 0, 0);
  endtask

  task automatic t_compact_and_limit();
    load({8'hFF, 8'h80 | (8'd3 << 5) | 8'd7}, 1);
    expect_q("R2", 7, 1, 1, 28, 1, 3);
    load({8'hFF, (8'd1 << 5) | 8'd31}, 1);
    expect_q("R2", 31, 0, 1, 124, 1, 1);
    expect_ready("R7", 1'b0);
    load(full_ent(0, 'h01, 1, 0, 3), 0);
    expect_q("R7", 3, 1, 1, 'h55, 1, 2);
    expect_ready("R7", 1'b0);
  endtask

  task automatic t_clear();
    pulse_clear();
    expect_q("R5", 3, 1, 0, 3, 0, 0);
    expect_q("R5", 31, 0, 0, 31, 0, 0);
    expect_ready("R5", 1'b1);
    @(negedge clk);
    tbl_clear = 1'b1; ent_valid = 1'b1; ent_compact = 1'b0;
    ent_data = full_ent(1, 'h40, 1, 3, 10);
    @(negedge clk);
    tbl_clear = 1'b0; ent_valid = 1'b0;
    expect_q("R5", 10, 1, 0, 10, 0, 0);
  endtask

  task automatic t_override_and_idle();
    load(full_ent(1, 'h01, 1, 1, 9), 0);
    expect_q("R9", 9, 1, 1, 'h01, 1, 1);
    load(full_ent(0, 'h02, 1, 2, 9), 0);
    expect_q("R6", 9, 1, 1, 'h02, 0, 2);
    @(negedge clk);
    ent_valid = 1'b0; ent_data = full_ent(1, 'h7F, 1, 3, 9);
    @(negedge clk);
    @(negedge clk);
    expect_q("R9", 9, 1, 1, 'h02, 0, 2);
    expect_q("R9", 12, 1, 0, 12, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full_and_class();
    t_compact_and_limit();
    t_clear();
    t_override_and_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule